// File: doc/BRIEF.md
# Multi-polynomial byte-serial CRC engine with compare

This block computes a running CRC over a stream of bytes. A data source offers one byte per cycle with a valid strobe, and the engine folds that byte into a 32-bit running value. One of three generator polynomials can be chosen: two 32-bit ones (0x04C11DB7 and 0x1EDC6F41) and one 16-bit one (0x1021). Each polynomial is written without its implicit top bit. Bits of each byte enter least-significant first. The running value is not reflected, and no final XOR is applied, so software reads the raw register.

A small word-addressed register port sets the mode, reloads the running value, loads a reference value and controls the error interrupt. When compare mode is on, the data source pulses an end-of-block strobe. The engine then checks the running value against the reference and, on a mismatch, raises a sticky error flag. A read of the error status clears that flag. While compare mode is on, the result register reads as zero. The interrupt line is the error flag gated by a mask bit.

Top module: `crc_multi_engine`

## Requirements
- R1: After reset the mode word reads 0, the mask and the error flag are 0, the interrupt output is low, and the running value equals the INIT parameter (default all ones).
- R2: Word 0 is the mode register. Bit 0 is enable, bit 1 is compare, bits 3:2 select the polynomial and bits 7:4 hold a stored bandwidth divider. It reads back these 8 bits, with bits 31:8 reading zero.
- R3: With enable set, each valid byte updates the running value bit by bit from bit 0 to bit 7. For each bit, feedback is the register's top bit XOR the data bit; the register shifts left and is XORed with the polynomial when feedback is 1. Polynomial code 0 selects 0x04C11DB7, code 1 selects 0x1EDC6F41, code 2 selects 0x1021 and code 3 behaves like code 0. No reflection and no final XOR is applied.
- R4: Valid bytes arriving while enable is 0 leave the running value unchanged.
- R5: Writing word 1 with bit 0 set reloads the running value with INIT (low 16 bits only, upper zero, under code 2) in the next cycle. This reload takes priority over a byte in the same cycle.
- R6: Under code 2 the register is 16 bits wide: feedback comes from bit 15, an update leaves bits 31:16 at zero, and the result reads with bits 31:16 zero.
- R7: Word 2 reads the running value, but reads as zero while compare is set.
- R8: Word 3 is a read/write 32-bit reference register (only its low 16 bits are compared under code 2).
- R9: On an end-of-block strobe with enable and compare set, a mismatch between the running value held before that cycle's byte and the reference sets the error flag in the next cycle. A match, or a strobe with compare clear, leaves the flag unchanged.
- R10: Word 7 bit 0 reads the error flag. A read of word 7 clears the flag in the next cycle, unless a new mismatch sets it in the same cycle.
- R11: Writing word 4 with bit 0 set sets the interrupt mask, and writing word 5 with bit 0 set clears it. Word 6 bit 0 reads the mask.
- R12: The interrupt output is high exactly when both the error flag and the mask are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for read-to-clear) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| dat_vld | input | 1 | Data byte valid |
| dat_byte | input | 8 | Data byte |
| dat_last | input | 1 | End-of-block strobe for compare |
| irq | output | 1 | Error interrupt |

## Verification
Every cycle, the assertions check several rules: the running value holds while the engine is disabled and no reload is pending, a reload lands INIT, and 16-bit updates leave the upper half clear. They also check that a compare mismatch sets the flag a cycle later, that a status read clears it, that the mask follows its set command, that the interrupt never rises without the mask, and that the result stays hidden in compare mode. Whether the CRC arithmetic itself is correct for each polynomial, including the bit order within a byte, can be shown only by the bench's byte streams checked against its independent bit-serial model.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

  localparam int CRC_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    POLY_ETH  = 2'd0,
    POLY_CAST = 2'd1,
    POLY_16   = 2'd2,
    POLY_ALT  = 2'd3
  } poly_sel_e;

  localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd1;
  localparam logic [ADDR_W-1:0] A_RESULT = 3'd2;
  localparam logic [ADDR_W-1:0] A_REF    = 3'd3;
  localparam logic [ADDR_W-1:0] A_MSET   = 3'd4;
  localparam logic [ADDR_W-1:0] A_MCLR   = 3'd5;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd6;
  localparam logic [ADDR_W-1:0] A_ERR    = 3'd7;

  function automatic logic [CRC_W-1:0] poly_word(poly_sel_e s);
    case (s)
      POLY_CAST: poly_word = 32'h1EDC_6F41;
      POLY_16:   poly_word = 32'h0000_1021;
      default:   poly_word = 32'h04C1_1DB7;
    endcase
  endfunction

  // Fold one byte, bit 0 first, into a non-reflected register.
  function automatic logic [CRC_W-1:0] fold_byte(logic [CRC_W-1:0] c,
                                                 logic [7:0] d,
                                                 poly_sel_e s);
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = c;
    for (int i = 0; i < 8; i++) begin
      fb  = ((s == POLY_16) ? acc[15] : acc[CRC_W-1]) ^ d[i];
      acc = {acc[CRC_W-2:0], 1'b0};
      if (fb) acc = acc ^ poly_word(s);
    end
    if (s == POLY_16) acc[CRC_W-1:16] = '0;
    fold_byte = acc;
  endfunction

endpackage

// File: rtl/crc_eng_regs.sv
module crc_eng_regs
  import crc_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CRC_W-1:0]  wdata,
  output logic [7:0]        mode_o,
  output logic [CRC_W-1:0]  ref_o,
  output logic              mask_o,
  output logic              reload_o
);

  logic [7:0]       mode_q, mode_d;
  logic [CRC_W-1:0] ref_q, ref_d;
  logic             mask_q, mask_d;
  logic             mode_we, ref_we;

  always_comb begin
    mode_we  = wr && (addr == A_MODE);
    ref_we   = wr && (addr == A_REF);
    mode_d   = mode_we ? wdata[7:0] : mode_q;
    ref_d    = ref_we ? wdata : ref_q;
    mask_d   = mask_q;
    if (wr && (addr == A_MSET) && wdata[0]) mask_d = 1'b1;
    else if (wr && (addr == A_MCLR) && wdata[0]) mask_d = 1'b0;
    reload_o = wr && (addr == A_CMD) && wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ref_q  <= ref_d;
      mask_q <= mask_d;
    end
  end

  assign mode_o = mode_q;
  assign ref_o  = ref_q;
  assign mask_o = mask_q;

  // R11
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_MSET && wdata[0]) |=> mask_o);

  // R11
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_MCLR && wdata[0]) |=> !mask_o);

endmodule

// File: rtl/crc_eng_datapath.sv
module crc_eng_datapath
  import crc_eng_pkg::*;
#(
  parameter logic [CRC_W-1:0] INIT = 32'hFFFF_FFFF
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  poly_sel_e        sel,
  input  logic             reload,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  output logic [CRC_W-1:0] crc_o
);

  localparam logic [CRC_W-1:0] INIT16 = {16'h0000, INIT[15:0]};

  logic [CRC_W-1:0] crc_q, crc_d;
  logic             upd;

  always_comb begin
    upd   = en && byte_vld;
    crc_d = crc_q;
    if (reload) crc_d = (sel == POLY_16) ? INIT16 : INIT;
    else if (upd) crc_d = fold_byte(crc_q, byte_in, sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= INIT;
    else        crc_q <= crc_d;
  end

  assign crc_o = (sel == POLY_16) ? {16'h0000, crc_q[15:0]} : crc_q;

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !en) |=> $stable(crc_q));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (crc_q[15:0] == INIT[15:0]));

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !reload && sel == POLY_16) |=> (crc_q[CRC_W-1:16] == '0));

endmodule

// File: rtl/crc_eng_cmp.sv
module crc_eng_cmp
  import crc_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             last,
  input  logic             narrow,
  input  logic [CRC_W-1:0] crc_val,
  input  logic [CRC_W-1:0] ref_val,
  input  logic             rd_clr,
  output logic             err_o
);

  logic             err_q, err_d;
  logic             miss;
  logic [CRC_W-1:0] ref_eff;

  always_comb begin
    ref_eff = narrow ? {16'h0000, ref_val[15:0]} : ref_val;
    miss    = arm && last && (crc_val != ref_eff);
    err_d   = err_q;
    if (miss)        err_d = 1'b1;
    else if (rd_clr) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o = err_q;

  // R9
  mismatch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && last && (crc_val != ref_eff)) |=> err_o);

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !(arm && last)) |=> !err_o);

endmodule

// File: rtl/crc_multi_engine.sv
module crc_multi_engine
  import crc_eng_pkg::*;
#(
  parameter logic [CRC_W-1:0] INIT = 32'hFFFF_FFFF
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CRC_W-1:0]  reg_wdata,
  output logic [CRC_W-1:0]  reg_rdata,
  input  logic              dat_vld,
  input  logic [7:0]        dat_byte,
  input  logic              dat_last,
  output logic              irq
);

  logic [7:0]       mode;
  logic [CRC_W-1:0] ref_val, crc_val;
  logic             mask, reload, err;
  logic             en, cmp_on;
  poly_sel_e        sel;

  assign en     = mode[0];
  assign cmp_on = mode[1];
  assign sel    = poly_sel_e'(mode[3:2]);

  crc_eng_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .mode_o(mode), .ref_o(ref_val), .mask_o(mask), .reload_o(reload)
  );

  crc_eng_datapath #(.INIT(INIT)) u_dp (
    .clk(clk), .rst_n(rst_n), .en(en), .sel(sel), .reload(reload),
    .byte_vld(dat_vld), .byte_in(dat_byte), .crc_o(crc_val)
  );

  crc_eng_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .arm(en && cmp_on), .last(dat_last),
    .narrow(sel == POLY_16), .crc_val(crc_val), .ref_val(ref_val),
    .rd_clr(reg_rd && reg_addr == A_ERR), .err_o(err)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MODE:   reg_rdata = {24'h0, mode};
      A_RESULT: reg_rdata = cmp_on ? '0 : crc_val;
      A_REF:    reg_rdata = ref_val;
      A_MASK:   reg_rdata = {31'h0, mask};
      A_ERR:    reg_rdata = {31'h0, err};
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = err && mask;

  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask && err));

  // R7
  result_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && reg_addr == A_RESULT) |-> (reg_rdata == '0));

endmodule

// File: tb/crc_multi_engine_bench.sv
`timescale 1ns/1ps
module crc_multi_engine_bench;

  localparam logic [31:0] INIT = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dat_vld = 1'b0, dat_last = 1'b0;
  logic [7:0]  dat_byte = '0;
  logic        irq;

  int tests = 0, fails = 0;
  bit done = 0;

  // behavioural model state
  logic [7:0]  m_mode;
  logic [31:0] m_crc, m_ref;
  bit          m_mask, m_err;

  always #10 clk = ~clk;

  crc_multi_engine #(.INIT(INIT)) u_crc_multi_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dat_vld(dat_vld), .dat_byte(dat_byte), .dat_last(dat_last), .irq(irq)
  );

  function automatic int wid();
    return (m_mode[3:2] == 2'd2) ? 16 : 32;
  endfunction

  function automatic logic [31:0] wmask();
    return (wid() == 16) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mdl_byte(logic [31:0] c, logic [7:0] b);
    int w;
    logic [31:0] p, m;
    bit t;
    w = wid();
    m = wmask();
    case (m_mode[3:2])
      2'd1: p = 32'h1EDC6F41;
      2'd2: p = 32'h00001021;
      default: p = 32'h04C11DB7;
    endcase
    for (int i = 0; i < 8; i++) begin
      t = c[w-1] ^ b[i];
      c = (c << 1) & m;
      if (t) c = c ^ p;
    end
    return c & m;
  endfunction

  function automatic logic [31:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: return {24'h0, m_mode};
      3'd2: return m_mode[1] ? 32'h0 : (m_crc & wmask());
      3'd3: return m_ref;
      3'd6: return {31'h0, m_mask};
      3'd7: return {31'h0, m_err};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // every-clock comparison of the interrupt line (R12)
  always @(negedge clk) if (rst_n && !done) chk({31'h0, irq}, {31'h0, m_err & m_mask}, "R12 irq");

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    case (a)
      3'd0: m_mode = d[7:0];
      3'd1: if (d[0]) m_crc = (m_mode[3:2] == 2'd2) ? {16'h0, INIT[15:0]} : INIT;
      3'd3: m_ref = d;
      3'd4: if (d[0]) m_mask = 1;
      3'd5: if (d[0]) m_mask = 0;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #2 chk(reg_rdata, exp_read(a), tag);
    @(posedge clk); #1;
    reg_rd = 1'b0;
    if (a == 3'd7) m_err = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    dat_vld = 1'b1; dat_byte = b;
    @(posedge clk); #1;
    dat_vld = 1'b0;
    if (m_mode[0]) m_crc = mdl_byte(m_crc, b);
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send(s[i]);
  endtask

  task automatic end_block();
    @(negedge clk);
    dat_last = 1'b1;
    @(posedge clk); #1;
    dat_last = 1'b0;
    if (m_mode[0] && m_mode[1] && ((m_crc & wmask()) != (m_ref & wmask()))) m_err = 1;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_mode = 0; m_crc = INIT; m_ref = 0; m_mask = 0; m_err = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, "R1 mode");
    rd(3'd2, "R1 result");
    rd(3'd6, "R1 mask");
    rd(3'd7, "R1 err");

    // R2 mode readback, divider stored, upper bits zero
    wr(3'd0, 32'hFFFF_FFA0);
    rd(3'd0, "R2 mode readback");

    // R4 disabled: bytes ignored
    send_str("xyz");
    rd(3'd2, "R4 ignored when disabled");

    // R3 each polynomial code
    for (int p = 0; p < 4; p++) begin
      wr(3'd0, {28'h0, p[1:0], 2'b01});
      wr(3'd1, 32'h1);
      send_str("ABCDEFG");
      send(8'h00); send(8'hFF); send(8'h80); send(8'h01);
      rd(3'd2, (p == 2) ? "R6 16-bit result" : "R3 poly result");
    end

    // R5 reload wins over same-cycle byte
    wr(3'd0, 32'h1);
    send_str("12");
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h1;
    dat_vld = 1'b1; dat_byte = 8'h5A;
    @(posedge clk); #1;
    reg_wr = 1'b0; dat_vld = 1'b0;
    m_crc = INIT;
    rd(3'd2, "R5 reload priority");

    // R6 upper cleared after 32 -> 16-bit switch and update
    send(8'h33);
    wr(3'd0, 32'h9);
    send(8'h44);
    wr(3'd0, 32'h1);
    rd(3'd2, "R6 upper zero after 16-bit update");

    // R8 reference register
    wr(3'd3, 32'hDEAD_BEEF);
    rd(3'd3, "R8 ref readback");

    // R7 hidden in compare mode
    wr(3'd0, 32'h3);
    wr(3'd1, 32'h1);
    send_str("hello");
    rd(3'd2, "R7 result hidden");

    // R11 mask set/clear
    wr(3'd4, 32'h1);
    rd(3'd6, "R11 mask set");
    wr(3'd5, 32'h0);
    rd(3'd6, "R11 clear needs bit0");
    wr(3'd5, 32'h1);
    rd(3'd6, "R11 mask clear");
    wr(3'd4, 32'h1);

    // R9 mismatch sets err, R12 irq raised
    end_block();
    rd(3'd7, "R9 mismatch err");
    rd(3'd7, "R10 read cleared err");

    // R9 match: load ref with the model's value
    wr(3'd0, 32'h1);
    rd(3'd2, "R3 value before match");
    wr(3'd3, m_crc);
    wr(3'd0, 32'h3);
    end_block();
    rd(3'd7, "R9 match no err");

    // R9 strobe with compare off
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h1);
    end_block();
    rd(3'd7, "R9 compare off no err");

    // R9/R6 16-bit compare ignores upper ref bits
    wr(3'd0, 32'hB);
    wr(3'd1, 32'h1);
    send_str("ABCDEFG");
    wr(3'd3, {16'hABCD, m_crc[15:0]});
    end_block();
    rd(3'd7, "R9 16-bit match");
    wr(3'd3, 32'h0);
    end_block();
    rd(3'd7, "R9 16-bit mismatch");
    rd(3'd7, "R10 cleared again");

    repeat (2) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule